// File: doc/BRIEF.md
# Signalling Channel Buffer with Interrupt

This block moves a low-rate signalling channel between a framed serial bus and a host. On the receive side it collects the one or two signalling bits that arrive in each frame into a byte. It hands that byte to the host once per packing cycle. On the transmit side it plays out a host-written byte, one or two bits per frame, and sends the same byte again for as long as the host leaves it alone. The bus framing logic around the block supplies a frame pulse, bit-cell ticks and a per-frame slot strobe carrying the received bits. The host sees the byte through a read strobe, a write strobe and a data pair.

Once per packing cycle, the block pulls an open-drain interrupt low. This marks the window in which the host may safely read the collected byte or write the next one. The interrupt goes away when the host touches the register or when the next frame begins. A rate input selects either two bits per frame over a cycle of four frames, or one bit per frame over a cycle of eight frames. An enable input controls the transmit slot and the interrupt, but reception always continues.

Top module: `sig_chan_buffer`

## Requirements
- R1: With `rate_slow` low, a packing cycle is 4 frames (phases 0..3) and each frame carries 2 bits. With it high, a cycle is 8 frames (phases 0..7) and each frame carries 1 bit, on lane 0 of `rx_bits`/`tx_bits`. Each frame pulse after the first one advances the phase by one, and the phase wraps to 0 after the last phase.
- R2: A slot strobe in phase p stores the received bits at byte position p. In 2-bit mode, `rx_bits[0]` goes to bit 2p and `rx_bits[1]` goes to bit 2p+1. In 1-bit mode, `rx_bits[0]` goes to bit p. The strobe in the last phase publishes the whole byte on `host_rdata` from the next cycle, so bits 1:0 come from the oldest frame. That byte then holds until the next last-phase strobe.
- R3: The frame pulse that starts phase 0 latches the write register for playout. In phase p, `tx_bits` carries bits 2p+1:2p in 2-bit mode. In 1-bit mode, `tx_bits` is {1, bit p}. A byte written during the last phase is therefore sent starting with the next frame.
- R4: If the host writes nothing, the same write register contents are played out again in every packing cycle.
- R5: After reset, the write register is 8'hFF, `irq_pull_low` is low and `tx_oe` is low. The read byte has no defined reset value.
- R6: The interrupt is set only in the last phase, at the `cell_tick` that starts bit cell 2 in 2-bit mode or bit cell 1 in 1-bit mode. Bit cell 0 starts at the frame pulse. The interrupt appears on `irq_pull_low` one cycle after that tick.
- R7: A host read or write clears the interrupt. So does a frame pulse, whichever comes first. The output is low in the cycle after either event.
- R8: While `chan_enable` is low, received bits are still stored and published, but `tx_oe` and `irq_pull_low` stay low.
- R9: After reset or a change of `rate_slow`, the block waits for the next frame pulse and makes that frame phase 0. Until that frame pulse, it stores no received bits, drives no transmit slot and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_slow | input | 1 | 1 selects 1 bit per frame over 8 frames; 0 selects 2 bits over 4 |
| chan_enable | input | 1 | Enables the transmit slot and the interrupt |
| frame_pulse | input | 1 | One-cycle strobe at the start of each frame (start of bit cell 0) |
| cell_tick | input | 1 | One-cycle strobe at the start of bit cells 1 and later |
| slot_strobe | input | 1 | One-cycle strobe when this frame's received signalling bits are valid |
| rx_bits | input | 2 | Received bits; lane 0 is the first bit |
| host_rd | input | 1 | Host read access strobe |
| host_wr | input | 1 | Host write access strobe |
| host_wdata | input | 8 | Byte to transmit |
| host_rdata | output | 8 | Last completed received byte |
| tx_bits | output | 2 | Bits for the current frame's transmit slot |
| tx_oe | output | 1 | Transmit slot drive enable |
| irq_pull_low | output | 1 | 1 pulls the open-drain interrupt line low |

## Verification
The hardest state to reach from the ports is a rate change in the middle of a packing cycle, with half-collected bits still in the accumulator. The block must then discard its phase and start over cleanly at the next frame pulse. The stimulus switches the rate at random frame boundaries with a fixed seed, so cycles of both lengths are cut short at every phase. The stimulus also toggles the enable and varies host accesses at random: some reads, some writes, and some frames with no access. This exercises both clearing paths of the interrupt, and a reference model in the bench tracks phase, resync state and the expected bytes.

// File: rtl/sigbuf_pkg.sv
package sigbuf_pkg;
  localparam int BYTE_W = 8;
  localparam int PH_W   = 3;

  // last phase of a packing cycle for the selected rate
  function automatic logic [PH_W-1:0] last_phase(input logic slow);
    return slow ? PH_W'(7) : PH_W'(3);
  endfunction

  // bit cell index at which the access window opens
  function automatic int unsigned irq_cell(input logic slow);
    return slow ? 1 : 2;
  endfunction

  // insert this frame's received bits into the accumulating byte
  function automatic logic [BYTE_W-1:0] pack_bits(input logic [BYTE_W-1:0] acc,
                                                  input logic [PH_W-1:0] ph,
                                                  input logic [1:0] bits,
                                                  input logic slow);
    logic [BYTE_W-1:0] r;
    r = acc;
    if (slow) r[ph] = bits[0];
    else      r[{ph[1:0], 1'b0} +: 2] = bits;
    return r;
  endfunction

  // pick this frame's transmit bits out of the held byte
  function automatic logic [1:0] play_bits(input logic [BYTE_W-1:0] d,
                                           input logic [PH_W-1:0] ph,
                                           input logic slow);
    return slow ? {1'b1, d[ph]} : d[{ph[1:0], 1'b0} +: 2];
  endfunction
endpackage

// File: rtl/sig_frame_seq.sv
module sig_frame_seq
  import sigbuf_pkg::*;
#(
  parameter int CELL_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rate_slow,
  input  logic            chan_enable,
  input  logic            frame_pulse,
  input  logic            cell_tick,
  input  logic            host_rd,
  input  logic            host_wr,
  output logic            slow_eff,
  output logic            primed,
  output logic [PH_W-1:0] phase,
  output logic            last_now,
  output logic            rate_chg,
  output logic            irq_flag
);
  localparam logic [CELL_W-1:0] CELL_MAX = '1;

  logic              slow_q, primed_q, irq_q;
  logic [PH_W-1:0]   phase_q;
  logic [CELL_W-1:0] cell_q;
  logic              access, irq_hit;

  assign slow_eff = slow_q;
  assign primed   = primed_q;
  assign phase    = phase_q;
  assign irq_flag = irq_q;
  assign rate_chg = (rate_slow != slow_q);
  assign last_now = (phase_q == last_phase(slow_q));
  assign access   = host_rd | host_wr;
  assign irq_hit  = primed_q && chan_enable && cell_tick && !frame_pulse && last_now &&
                    (cell_q == CELL_W'(irq_cell(slow_q) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q   <= 1'b0;
      primed_q <= 1'b0;
      phase_q  <= '0;
      cell_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      slow_q <= rate_slow;
      if (rate_chg) begin
        primed_q <= 1'b0;
      end else if (frame_pulse) begin
        primed_q <= 1'b1;
        phase_q  <= (primed_q && !last_now) ? phase_q + 1'b1 : '0;
      end
      if (frame_pulse) cell_q <= '0;
      else if (cell_tick && cell_q != CELL_MAX) cell_q <= cell_q + 1'b1;
      if (frame_pulse || access || rate_chg) irq_q <= 1'b0;
      else if (irq_hit) irq_q <= 1'b1;
    end
  end

  assert_phase_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (phase_q <= last_phase(slow_q)));
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && !rate_chg && primed_q && last_now) |=> (phase_q == '0));
  assert_irq_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (primed_q && last_now));
  assert_irq_fp_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !irq_q);
  assert_irq_acc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> !irq_q);
  assert_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg |=> !primed_q);
endmodule

// File: rtl/sig_rx_pack.sv
module sig_rx_pack
  import sigbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_strobe,
  input  logic [1:0]        rx_bits,
  input  logic              primed,
  input  logic              last_now,
  input  logic              slow,
  input  logic [PH_W-1:0]   phase,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] acc_q, rd_q, merged;
  logic              take, publish;

  assign merged  = pack_bits(acc_q, phase, rx_bits, slow);
  assign take    = slot_strobe && primed;
  assign publish = take && last_now;
  assign rd_data = rd_q;

  // data registers carry no reset: the read byte is undefined until filled
  always_ff @(posedge clk) begin
    if (take)    acc_q <= merged;
    if (publish) rd_q  <= merged;
  end

  assert_rd_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !publish |=> $stable(rd_q));
endmodule

// File: rtl/sig_tx_play.sv
module sig_tx_play
  import sigbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              frame_pulse,
  input  logic              rate_chg,
  input  logic              primed,
  input  logic              last_now,
  input  logic              slow,
  input  logic [PH_W-1:0]   phase,
  input  logic              chan_enable,
  output logic [1:0]        tx_bits,
  output logic              tx_oe
);
  logic [BYTE_W-1:0] wr_q, hold_q;
  logic              cycle_start;

  assign cycle_start = frame_pulse && !rate_chg && (!primed || last_now);
  assign tx_bits     = play_bits(hold_q, phase, slow);
  assign tx_oe       = chan_enable && primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '1;
      hold_q <= '1;
    end else begin
      if (host_wr) wr_q <= host_wdata;
      if (cycle_start) hold_q <= host_wr ? host_wdata : wr_q;
    end
  end

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(wr_q));
  assert_hold_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |=> $stable(hold_q));
endmodule

// File: rtl/sig_chan_buffer.sv
module sig_chan_buffer
  import sigbuf_pkg::*;
#(
  parameter int CELL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_slow,
  input  logic              chan_enable,
  input  logic              frame_pulse,
  input  logic              cell_tick,
  input  logic              slot_strobe,
  input  logic [1:0]        rx_bits,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic [1:0]        tx_bits,
  output logic              tx_oe,
  output logic              irq_pull_low
);
  logic            slow_eff, primed, last_now, rate_chg, irq_flag;
  logic [PH_W-1:0] phase;

  sig_frame_seq #(.CELL_W(CELL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .chan_enable(chan_enable),
    .frame_pulse(frame_pulse), .cell_tick(cell_tick), .host_rd(host_rd),
    .host_wr(host_wr), .slow_eff(slow_eff), .primed(primed), .phase(phase),
    .last_now(last_now), .rate_chg(rate_chg), .irq_flag(irq_flag)
  );

  sig_rx_pack u_rx (
    .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe), .rx_bits(rx_bits),
    .primed(primed), .last_now(last_now), .slow(slow_eff), .phase(phase),
    .rd_data(host_rdata)
  );

  sig_tx_play u_tx (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .frame_pulse(frame_pulse), .rate_chg(rate_chg), .primed(primed),
    .last_now(last_now), .slow(slow_eff), .phase(phase),
    .chan_enable(chan_enable), .tx_bits(tx_bits), .tx_oe(tx_oe)
  );

  assign irq_pull_low = irq_flag && chan_enable;

  assert_quiet_unprimed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (!tx_oe && !irq_pull_low));
endmodule

// File: tb/tb_sig_chan_buffer.sv
module tb_sig_chan_buffer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rate_slow, chan_enable, frame_pulse, cell_tick, slot_strobe;
  logic [1:0] rx_bits;
  logic       host_rd, host_wr;
  logic [7:0] host_wdata, host_rdata;
  logic [1:0] tx_bits;
  logic       tx_oe, irq_pull_low;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  bit       m_slow, m_primed;
  int       m_phase;
  bit [7:0] m_wr, m_hold, m_acc, m_rd;
  bit       m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_chan_buffer dut (
    .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .chan_enable(chan_enable),
    .frame_pulse(frame_pulse), .cell_tick(cell_tick), .slot_strobe(slot_strobe),
    .rx_bits(rx_bits), .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .tx_bits(tx_bits), .tx_oe(tx_oe), .irq_pull_low(irq_pull_low)
  );

  function automatic int m_last(input bit slow);
    return slow ? 7 : 3;
  endfunction

  function automatic int m_target(input bit slow);
    return slow ? 1 : 2;
  endfunction

  function automatic bit [1:0] exp_tx(input bit [7:0] d, input int ph, input bit slow);
    if (slow) return {1'b1, d[ph]};
    return {d[2*ph+1], d[2*ph]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic change_rate(input bit slow);
    rate_slow = slow;
    step();
    step();
    m_slow = slow;
    m_primed = 0;
    m_irq = 0;
    check("R9 resync tx_oe", {7'd0, tx_oe}, 8'd0);
    check("R9 resync irq", {7'd0, irq_pull_low}, 8'd0);
  endtask

  // one frame; acc_mode 0 = read after window, 1 = write, 2 = no access
  task automatic run_frame(input int acc_mode, input bit [7:0] wdata);
    bit [1:0] bits;
    bit       load;
    frame_pulse = 1;
    step();
    frame_pulse = 0;
    load = !m_primed || (m_phase == m_last(m_slow));
    if (load) m_hold = m_wr;
    m_phase = (m_primed && m_phase != m_last(m_slow)) ? m_phase + 1 : 0;
    m_primed = 1;
    m_irq = 0;
    check("R7 irq cleared by frame pulse", {7'd0, irq_pull_low}, 8'd0);
    check(chan_enable ? "R3 tx_oe" : "R8 tx_oe off", {7'd0, tx_oe}, {7'd0, chan_enable});
    if (chan_enable)
      check("R3 R4 R5 tx bits", {6'd0, tx_bits}, {6'd0, exp_tx(m_hold, m_phase, m_slow)});
    step();
    bits = 2'($urandom);
    slot_strobe = 1;
    rx_bits = bits;
    step();
    slot_strobe = 0;
    if (m_slow) m_acc[m_phase] = bits[0];
    else begin
      m_acc[2*m_phase]   = bits[0];
      m_acc[2*m_phase+1] = bits[1];
    end
    if (m_phase == m_last(m_slow)) begin
      m_rd = m_acc;
      check(chan_enable ? "R2 published byte" : "R8 capture while disabled",
            host_rdata, m_rd);
    end
    for (int c = 1; c < 8; c++) begin
      cell_tick = 1;
      step();
      cell_tick = 0;
      if (c < m_target(m_slow))
        check("R6 irq not early", {7'd0, irq_pull_low}, 8'd0);
      if (c == m_target(m_slow)) begin
        m_irq = chan_enable && (m_phase == m_last(m_slow));
        check(chan_enable ? "R6 irq window" : "R8 irq off",
              {7'd0, irq_pull_low}, {7'd0, m_irq});
        if (acc_mode == 0) begin
          host_rd = 1;
          step();
          host_rd = 0;
          m_irq = 0;
          check("R7 irq cleared by read", {7'd0, irq_pull_low}, 8'd0);
          check("R2 read data", host_rdata, m_rd);
        end else if (acc_mode == 1) begin
          host_wr = 1;
          host_wdata = wdata;
          step();
          host_wr = 0;
          m_wr = wdata;
          m_irq = 0;
          check("R7 irq cleared by write", {7'd0, irq_pull_low}, 8'd0);
        end
      end
      step();
    end
    check("R6 irq held to frame end", {7'd0, irq_pull_low}, {7'd0, m_irq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 0;
    rate_slow = 0; chan_enable = 1; frame_pulse = 0; cell_tick = 0;
    slot_strobe = 0; rx_bits = 0; host_rd = 0; host_wr = 0; host_wdata = 0;
    m_slow = 0; m_primed = 0; m_phase = 0; m_wr = 8'hFF; m_hold = 8'hFF;
    m_acc = 0; m_rd = 0; m_irq = 0;
    repeat (3) step();
    check("R5 reset irq", {7'd0, irq_pull_low}, 8'd0);
    check("R5 reset tx_oe", {7'd0, tx_oe}, 8'd0);
    rst_n = 1;
    step();
    // R9: unprimed frame behaviour before first pulse
    slot_strobe = 1; rx_bits = 2'b11; step(); slot_strobe = 0;
    check("R9 no tx before first pulse", {7'd0, tx_oe}, 8'd0);
    // directed: preset value played out twice without writes (R5, R4)
    for (int f = 0; f < 8; f++) run_frame(2, 8'h00);
    // directed: write then retransmission over two cycles (R3, R4)
    for (int f = 0; f < 4; f++) run_frame(f == 3 ? 1 : 0, 8'h1E);
    for (int f = 0; f < 8; f++) run_frame(2, 8'h00);
    // directed: slow rate (R1)
    change_rate(1);
    for (int f = 0; f < 16; f++) run_frame(f == 7 ? 1 : 0, 8'hC5);
    // directed: disabled channel (R8)
    chan_enable = 0;
    for (int f = 0; f < 8; f++) run_frame(2, 8'h00);
    chan_enable = 1;
    change_rate(0);
    // random mix: access kinds, enable, mid-cycle rate switches (R1, R9)
    for (int f = 0; f < 400; f++) begin
      int r;
      r = int'($urandom_range(0, 19));
      if (r == 0) change_rate(!m_slow);
      if (r == 1) chan_enable = !chan_enable;
      run_frame(int'($urandom_range(0, 2)), 8'($urandom));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule